// File: doc/BRIEF.md
# Per-Channel Multi-Hit Capture Buffer

This block is the digital control for a single detector channel during a long train of bunch crossings. A bunch strobe marks each crossing. While the train is active, a stamp counter numbers the crossings. Two comparator outputs from the analog front end act on each crossing. The lower-threshold comparator holds off the integrator reset for that crossing. The selected trigger source commits the crossing to the next free slot of a four-deep event store. A commit writes the crossing stamp and the gain-range bit into that slot. It also pulses the matching strobe toward the analog sample buffers.

Once the four slots are used, later hits in the same train are dropped and cause dead time. No slot is overwritten. After the train ends, the conversion logic drains the stored records in capture order through a valid/ready read port.

The read port follows these back-pressure rules:
- The consumer may hold `rd_ready` low for any length of time. The offered record stays unchanged while it does.
- A record is consumed only in a cycle where `rd_valid` and `rd_ready` are both high.
- The port offers nothing while the train is active. Raising `train_on` withdraws the records that were not read.

Top module: `evt_capture_chan`

## Requirements
- R1: After reset, `occ_count` is 0, `store_strobe` is 0, `rst_inhibit` is 0 and `rd_valid` is 0.
- R2: `trig_mode` selects the commit trigger:
  - 0: `cmp_high` alone.
  - 1: `ext_trig` alone.
  - 2: `nbr_left` OR `nbr_right`.
  - 3: `cmp_high` OR `nbr_left` OR `nbr_right`.
- R3: An active crossing is a cycle with `bx_tick` high, `train_on` high, and not the train-start cycle. On an active crossing whose trigger is true while `occ_count` < 4, the next cycle shows two results:
  - `store_strobe` bit number equal to the old `occ_count` pulses high for exactly one cycle.
  - `occ_count` is one higher.
- R4: With `occ_count` equal to 4, triggers produce no strobe. The count stays at 4 and the stored records are unchanged.
- R5: A record's stamp equals the number of active crossings since train start before the storing one, so the first crossing stores 0. The stamp stops at 8191 rather than wrapping.
- R6: A record's range bit equals `cmp_range` on the storing crossing.
- R7: On each active crossing, `rst_inhibit` takes the value of `cmp_low` in the next cycle and holds it until the next active crossing. The cycle after `train_on` is low, `rst_inhibit` is 0.
- R8: The cycle where `train_on` rises clears the count, the stamp counter and the read position, visible in the next cycle. A `bx_tick` in that cycle is ignored.
- R9: `rd_valid` is high only while `train_on` is low and unread records remain. It offers records oldest first on `rd_stamp` and `rd_range`, holds them while `rd_ready` is low, and advances on valid and ready.
- R10: `bx_tick` and triggers while `train_on` is low change neither the count, nor the strobes, nor later stamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_on | input | 1 | High while the bunch train is active |
| bx_tick | input | 1 | One-cycle strobe per bunch crossing |
| cmp_low | input | 1 | Lower-threshold comparator, requests reset hold-off |
| cmp_high | input | 1 | Higher-threshold comparator, self trigger |
| cmp_range | input | 1 | High-gain-range comparator |
| ext_trig | input | 1 | External trigger |
| nbr_left | input | 1 | Trigger from the left neighbour channel |
| nbr_right | input | 1 | Trigger from the right neighbour channel |
| trig_mode | input | 2 | Trigger source select (R2) |
| rst_inhibit | output | 1 | Hold-off for the front-end reset |
| store_strobe | output | 4 | One-hot commit pulse per sample buffer |
| occ_count | output | 3 | Number of slots used in this train |
| rd_valid | output | 1 | Read record offered |
| rd_ready | input | 1 | Consumer accepts the record |
| rd_stamp | output | 13 | Crossing stamp of the offered record |
| rd_range | output | 1 | Range bit of the offered record |

## Verification
Every registered result is due one cycle after the rising edge that samples the crossing:
- the strobe pulse;
- the new count;
- the reset hold-off;
- the clear at train start.

The read-port outputs depend combinationally on `train_on` and on registered state. They therefore change in the same cycle `train_on` moves and one cycle after a handshake. The bench drives inputs on the falling edge and advances a behavioural model at each rising edge. It compares every output 1 ns after that edge, so each registered result is checked in the cycle it first appears. Directed checks sampled at the falling edge confirm the counts for the trigger modes, the saturation and the ignored crossings.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;

  typedef enum logic [1:0] {
    TRIG_SELF     = 2'd0,
    TRIG_EXT      = 2'd1,
    TRIG_NBR      = 2'd2,
    TRIG_SELF_NBR = 2'd3
  } trig_mode_e;

endpackage

// File: rtl/bx_stamp_counter.sv
module bx_stamp_counter #(
  parameter int STAMP_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               advance,
  output logic [STAMP_W-1:0] stamp
);

  localparam logic [STAMP_W-1:0] STAMP_MAX = {STAMP_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      stamp <= '0;
    end else if (advance && stamp != STAMP_MAX) begin
      stamp <= stamp + 1'b1;
    end
  end

  // R5: saturated stamp never wraps
  a_r5_stamp_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (stamp == STAMP_MAX && !clear) |=> stamp == STAMP_MAX);

endmodule

// File: rtl/trig_select.sv
module trig_select
  import evt_cap_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       self_hit,
  input  logic       ext_hit,
  input  logic       nbr_l,
  input  logic       nbr_r,
  output logic       fire
);

  trig_mode_e sel;
  logic       nbr_any;

  assign sel     = trig_mode_e'(mode);
  assign nbr_any = nbr_l | nbr_r;

  always_comb begin
    unique case (sel)
      TRIG_SELF:     fire = self_hit;
      TRIG_EXT:      fire = ext_hit;
      TRIG_NBR:      fire = nbr_any;
      TRIG_SELF_NBR: fire = self_hit | nbr_any;
      default:       fire = 1'b0;
    endcase
  end

endmodule

// File: rtl/event_store.sv
module event_store #(
  parameter int DEPTH   = 4,
  parameter int STAMP_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_req,
  input  logic [STAMP_W-1:0] wr_stamp,
  input  logic               wr_range,
  input  logic               rd_open,
  input  logic               rd_ready,
  output logic [DEPTH-1:0]   strobe,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic               rd_valid,
  output logic [STAMP_W-1:0] rd_stamp,
  output logic               rd_range
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [STAMP_W-1:0] stamp_mem [DEPTH];
  logic               range_mem [DEPTH];
  logic [CW-1:0]      rptr;
  logic               full;
  logic               take;
  logic               rd_fire;

  assign full    = (occ == FULL_CNT);
  assign take    = wr_req && !full && !clear;
  assign rd_fire = rd_valid && rd_ready && !clear;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_slot;
    assign hit_slot = take && (occ == CW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stamp_mem[i] <= '0;
        range_mem[i] <= 1'b0;
        strobe[i]    <= 1'b0;
      end else begin
        strobe[i] <= hit_slot;
        if (hit_slot) begin
          stamp_mem[i] <= wr_stamp;
          range_mem[i] <= wr_range;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      occ  <= '0;
      rptr <= '0;
    end else begin
      if (take)    occ  <= occ + 1'b1;
      if (rd_fire) rptr <= rptr + 1'b1;
    end
  end

  assign rd_valid = rd_open && (rptr != occ);
  assign rd_stamp = stamp_mem[rptr[PW-1:0]];
  assign rd_range = range_mem[rptr[PW-1:0]];

  // R4: count never exceeds the number of slots
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);

  // R4: a full store stays full and quiet
  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> (occ == FULL_CNT && strobe == '0));

  // R3: at most one buffer strobed per cycle
  a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  // R9: read position never passes the write position
  a_r9_rptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rptr <= occ);

  // R9: offered record holds under back-pressure
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !clear) |=> ($stable(rd_stamp) && $stable(rd_range)));

endmodule

// File: rtl/evt_capture_chan.sv
module evt_capture_chan #(
  parameter int DEPTH   = 4,
  parameter int STAMP_W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       train_on,
  input  logic                       bx_tick,
  input  logic                       cmp_low,
  input  logic                       cmp_high,
  input  logic                       cmp_range,
  input  logic                       ext_trig,
  input  logic                       nbr_left,
  input  logic                       nbr_right,
  input  logic [1:0]                 trig_mode,
  output logic                       rst_inhibit,
  output logic [DEPTH-1:0]           store_strobe,
  output logic [$clog2(DEPTH+1)-1:0] occ_count,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [STAMP_W-1:0]         rd_stamp,
  output logic                       rd_range
);

  logic               train_q;
  logic               train_start;
  logic               active_tick;
  logic               trig_fire;
  logic [STAMP_W-1:0] stamp;

  assign train_start = train_on && !train_q;
  assign active_tick = bx_tick && train_on && !train_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      train_q     <= 1'b0;
      rst_inhibit <= 1'b0;
    end else begin
      train_q <= train_on;
      if (!train_on)        rst_inhibit <= 1'b0;
      else if (active_tick) rst_inhibit <= cmp_low;
    end
  end

  bx_stamp_counter #(.STAMP_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (train_start),
    .advance (active_tick),
    .stamp   (stamp)
  );

  trig_select u_trig (
    .mode     (trig_mode),
    .self_hit (cmp_high),
    .ext_hit  (ext_trig),
    .nbr_l    (nbr_left),
    .nbr_r    (nbr_right),
    .fire     (trig_fire)
  );

  event_store #(.DEPTH(DEPTH), .STAMP_W(STAMP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (train_start),
    .wr_req   (active_tick && trig_fire),
    .wr_stamp (stamp),
    .wr_range (cmp_range),
    .rd_open  (!train_on),
    .rd_ready (rd_ready),
    .strobe   (store_strobe),
    .occ      (occ_count),
    .rd_valid (rd_valid),
    .rd_stamp (rd_stamp),
    .rd_range (rd_range)
  );

  // R8: train start empties the store
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    train_start |=> occ_count == '0);

  // R9: nothing offered during the train
  a_r9_read_closed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !train_on);

  // R7: hold-off released once the train is over
  a_r7_inhibit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !train_on |=> !rst_inhibit);

  // R10: ticks outside the train commit nothing
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !train_on |=> store_strobe == '0);

endmodule

// File: tb/evt_capture_chan_test.sv
module evt_capture_chan_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_on = 1'b0, bx_tick = 1'b0, cmp_low = 1'b0, cmp_high = 1'b0;
  logic        cmp_range = 1'b0, ext_trig = 1'b0, nbr_left = 1'b0, nbr_right = 1'b0;
  logic [1:0]  trig_mode = 2'd0;
  logic        rd_ready = 1'b0;
  logic        rst_inhibit, rd_valid, rd_range;
  logic [3:0]  store_strobe;
  logic [2:0]  occ_count;
  logic [12:0] rd_stamp;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  int          m_cnt = 0, m_occ = 0, m_rp = 0;
  int          m_ts[4];
  bit          m_rg[4];
  bit          m_inh = 0, m_tq = 0;
  logic [3:0]  m_strobe = '0;

  always #2.5 clk = ~clk;

  evt_capture_chan uut (
    .clk(clk), .rst_n(rst_n), .train_on(train_on), .bx_tick(bx_tick),
    .cmp_low(cmp_low), .cmp_high(cmp_high), .cmp_range(cmp_range),
    .ext_trig(ext_trig), .nbr_left(nbr_left), .nbr_right(nbr_right),
    .trig_mode(trig_mode), .rst_inhibit(rst_inhibit),
    .store_strobe(store_strobe), .occ_count(occ_count),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_stamp(rd_stamp),
    .rd_range(rd_range)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
    end
  endtask

  function automatic bit trig_of(logic [1:0] md);
    case (md)
      2'd0: return cmp_high;
      2'd1: return ext_trig;
      2'd2: return nbr_left | nbr_right;
      default: return cmp_high | nbr_left | nbr_right;
    endcase
  endfunction

  always @(posedge clk) begin
    bit start, atick, fire;
    m_strobe = '0;
    if (!rst_n) begin
      m_cnt = 0; m_occ = 0; m_rp = 0; m_inh = 0; m_tq = 0;
    end else begin
      start = train_on && !m_tq;
      atick = bx_tick && train_on && !start;
      fire  = !train_on && (m_rp < m_occ) && rd_ready;
      if (start) begin
        m_occ = 0; m_rp = 0; m_cnt = 0;
      end else begin
        if (atick) begin
          m_inh = cmp_low;
          if (trig_of(trig_mode) && m_occ < 4) begin
            m_ts[m_occ] = m_cnt;
            m_rg[m_occ] = cmp_range;
            m_strobe[m_occ] = 1'b1;
            m_occ++;
          end
          if (m_cnt < 8191) m_cnt++;
        end
        if (fire) m_rp++;
      end
      if (!train_on) m_inh = 0;
      m_tq = train_on;
    end
    #1;
    if (rst_n) begin
      check("R3 count", occ_count, m_occ);
      check("R3 strobe", store_strobe, m_strobe);
      check("R7 inhibit", rst_inhibit, m_inh);
      check("R9 valid", rd_valid, (!train_on && m_rp < m_occ));
      if (rd_valid && m_rp < m_occ) begin
        check("R5 stamp", rd_stamp, m_ts[m_rp]);
        check("R6 range", rd_range, m_rg[m_rp]);
      end
    end
  end

  task automatic step(bit tk, bit lo, bit hi, bit rg, bit ex, bit nl, bit nr);
    bx_tick = tk; cmp_low = lo; cmp_high = hi; cmp_range = rg;
    ext_trig = ex; nbr_left = nl; nbr_right = nr;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      rd_ready = (i % 3) != 1;
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", occ_count, 0);
    check("R1 strobe", store_strobe, 0);
    check("R1 inhibit", rst_inhibit, 0);
    check("R1 valid", rd_valid, 0);
    rst_n = 1'b1;
    idle(2);

    // train 1: self trigger, tick on start cycle ignored (R8)
    trig_mode = 2'd0; train_on = 1'b1;
    step(1, 1, 1, 1, 0, 0, 0);
    check("R8 start tick ignored", occ_count, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 1, 1, 1);
    idle(2);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0);
    check("R4 four stored", occ_count, 4);
    step(1, 1, 1, 1, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0, 0);
    check("R4 saturated", occ_count, 4);
    train_on = 1'b0;
    // R10 ticks and hits with train off
    step(1, 1, 1, 1, 1, 1, 1);
    step(1, 0, 1, 0, 1, 1, 1);
    check("R10 idle count", occ_count, 4);
    check("R10 idle strobe", store_strobe, 0);
    idle(1);
    drain(8);
    check("R9 drained", rd_valid, 0);

    // train 2: external trigger
    trig_mode = 2'd1; train_on = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    check("R8 cleared", occ_count, 0);
    step(1, 0, 1, 0, 0, 1, 1);
    step(1, 0, 0, 1, 1, 0, 0);
    step(1, 1, 0, 0, 1, 0, 0);
    idle(1);
    check("R2 external", occ_count, 2);
    train_on = 1'b0; idle(1); drain(4);

    // train 3: neighbour trigger, partial read then new train withdraws
    trig_mode = 2'd2; train_on = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 1, 0);
    step(1, 1, 0, 0, 0, 0, 1);
    idle(1);
    check("R2 neighbour", occ_count, 2);
    train_on = 1'b0; idle(1);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    idle(2);

    // train 4: self or neighbour
    trig_mode = 2'd3; train_on = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    check("R9 withdrawn", rd_valid, 0);
    step(1, 0, 1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0, 0, 1);
    idle(1);
    check("R2 self or neighbour", occ_count, 3);
    train_on = 1'b0; idle(1); drain(6);

    // train 5: stamp saturation
    trig_mode = 2'd0; train_on = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 8200; i++) step(1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 0, 0, 0);
    idle(1);
    train_on = 1'b0;
    @(negedge clk);
    check("R5 first stamp", rd_stamp, 0);
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
    check("R5 saturated stamp", rd_stamp, 8191);
    drain(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule